// File: doc/BRIEF.md
# Reset-Configured Endian Data Lane

This block sits between a 32-bit core data port and a byte-addressed memory whose bus carries four byte lanes. Lane k (bits 8k+7 down to 8k) always holds the memory byte whose address ends in k. The block places core write data on the right lanes, produces the matching byte-write strobes, and turns lane data returned by the memory into a right-aligned value for the core. Byte, halfword and word sizes are supported, and the low address bits select the lanes.

The byte order is chosen once per reset. A configuration pin is sampled on every clock edge while the synchronous reset is held, and the last sample decides the order. After reset the order stays fixed, whatever the pin does. Little-endian is the default, used when the pin is low. Big-endian mode is byte-invariant: single bytes always land on the same lane, and only the order of bytes inside a halfword or word is reversed.

A small two-state machine holds the order. In state `ST_LITTLE` or `ST_BIG`, the transition SAMPLE (taken on each clock edge while reset is asserted) loads the state chosen by the pin. The transition HOLD (taken on every edge out of reset) keeps the state. The write path and the read path are independent and can both carry a transfer in the same cycle. Each registers its result, so the result appears one clock after the request.

Top module: `endian_lane`

## Requirements
- R1: While `rst_n` is low, `cfg_big_pin` is sampled on each rising clock edge. `big_mode` shows the last sample taken during reset: 1 selects big-endian and 0 selects little-endian, which is the default.
- R2: Once `rst_n` is high, changes on `cfg_big_pin` have no effect on `big_mode` or on any lane ordering, up to the next reset.
- R3: Little-endian word write: memory byte k of the word goes to lane k, so 0x12345678 gives lanes 0..3 = 78, 56, 34, 12 (`mem_wdata` = 0x12345678) and `mem_wstrb` = 4'b1111.
- R4: Big-endian word write: 0x12345678 gives lanes 0..3 = 12, 34, 56, 78 (`mem_wdata` = 0x78563412) and `mem_wstrb` = 4'b1111.
- R5: Halfword write uses lanes 2a and 2a+1, where a = address bit 1; address bit 0 is ignored. In little-endian mode the low byte goes to lane 2a (0x00FF at address 0 gives 0x000000FF). In big-endian mode the high byte goes to lane 2a (0x0000FF00). The strobe is 4'b0011 for a=0 and 4'b1100 for a=1.
- R6: Byte write puts data bits 7:0 on lane `wr_addr` in both modes, with a one-hot strobe on that lane.
- R7: Word read is the inverse of the word write for the latched mode. In big-endian mode, lanes 0x78563412 read back as 0x12345678.
- R8: Halfword and byte reads take the same lanes as writes of the same size and address, right-align the value, and fill the upper bits with zeros. When `rd_signed` is 1, the upper bits are filled with the value's top bit instead.
- R9: Each result is registered: `mem_wvalid` and `core_rvalid` follow `wr_valid` and `rd_valid` one clock later. In a cycle with no write, `mem_wdata` and `mem_wstrb` are zero. In a cycle with no read, `core_rdata` is zero.
- R10: Size code 2'b00 selects byte, 2'b01 halfword, 2'b10 word. Code 2'b11 also selects word.
- R11: A write and a read accepted in the same cycle are both completed correctly in the following cycle.
- R12: While reset is asserted, `mem_wvalid`, `mem_wdata`, `mem_wstrb`, `core_rvalid` and `core_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_big_pin | input | 1 | Byte-order selection, sampled only while reset is held |
| wr_valid | input | 1 | Write request this cycle |
| wr_size | input | 2 | Write size code |
| wr_addr | input | 2 | Low address bits of the write |
| wr_data | input | 32 | Right-aligned write value from the core |
| rd_valid | input | 1 | Read data from memory present this cycle |
| rd_size | input | 2 | Read size code |
| rd_addr | input | 2 | Low address bits of the read |
| rd_signed | input | 1 | Sign-extend a halfword or byte read |
| mem_rdata | input | 32 | Lane data returned by memory |
| mem_wvalid | output | 1 | Write lanes valid |
| mem_wdata | output | 32 | Write data arranged by lane |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| core_rvalid | output | 1 | Read result valid |
| core_rdata | output | 32 | Right-aligned, extended read value |
| big_mode | output | 1 | Latched byte order, 1 = big-endian |

## Verification
The write reordering and the read reordering can fall in the same cycle, since the two paths share only the latched mode. The bench provokes this by driving a write and a read in the same cycle for every size, address and sign setting. It does so in both modes, with different data on each path, so that a swap of lanes between paths, or a read picking up write data, shows up. Each cycle's pair of expected results is queued when the request is driven. The pair is compared one clock later against both output groups, so an error on one path cannot hide behind the other.

// File: rtl/endian_lane_pkg.sv
`timescale 1ns/1ps
package endian_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_LITTLE = 1'b0,
        ST_BIG    = 1'b1
    } order_state_e;

endpackage

// File: rtl/endian_order_fsm.sv
`timescale 1ns/1ps
module endian_order_fsm
    import endian_lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_pin,
    output logic big_mode
);

    order_state_e state_q;
    order_state_e state_d;

    // SAMPLE while reset is held, HOLD otherwise
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = cfg_pin ? ST_BIG : ST_LITTLE;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_LITTLE: big_mode = 1'b0;
            ST_BIG:    big_mode = 1'b1;
        endcase
    end

    AST_MODE_SAMPLED: assert property (@(posedge clk)
        !rst_n |=> (big_mode == $past(cfg_pin))); // R1

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_pin) |=> $stable(big_mode)); // R2

endmodule

// File: rtl/endian_wr_lane.sv
`timescale 1ns/1ps
module endian_wr_lane
    import endian_lane_pkg::*;
#(
    parameter  int LANE_W = 8,
    parameter  int NLANES = 4,
    localparam int AW     = $clog2(NLANES),
    localparam int BUS_W  = LANE_W * NLANES
) (
    input  logic              big_i,
    input  logic [1:0]        size_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [BUS_W-1:0]  lanes_o,
    output logic [NLANES-1:0] strb_o
);

    acc_size_e size_e;
    int        unit_n;
    int        base;

    assign size_e = acc_size_e'(size_i);

    always_comb begin
        unique case (size_e)
            SZ_BYTE:          unit_n = 1;
            SZ_HALF:          unit_n = 2;
            SZ_WORD, SZ_WIDE: unit_n = NLANES;
        endcase
        base = int'(addr_i) & ~(unit_n - 1);
    end

    for (genvar j = 0; j < NLANES; j++) begin : g_lane
        int                off_v;
        int                src_v;
        logic              hit_v;
        logic [LANE_W-1:0] byte_v;

        always_comb begin
            off_v = j - base;
            hit_v = (off_v >= 0) && (off_v < unit_n);
            src_v = 0;
            if (hit_v) begin
                src_v = big_i ? (unit_n - 1 - off_v) : off_v;
            end
            byte_v = hit_v ? data_i[src_v*LANE_W +: LANE_W] : '0;
        end

        assign lanes_o[j*LANE_W +: LANE_W] = byte_v;
        assign strb_o[j]                   = hit_v;
    end

endmodule

// File: rtl/endian_rd_lane.sv
`timescale 1ns/1ps
module endian_rd_lane
    import endian_lane_pkg::*;
#(
    parameter  int LANE_W = 8,
    parameter  int NLANES = 4,
    localparam int AW     = $clog2(NLANES),
    localparam int BUS_W  = LANE_W * NLANES
) (
    input  logic             big_i,
    input  logic [1:0]       size_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             signed_i,
    input  logic [BUS_W-1:0] lanes_i,
    output logic [BUS_W-1:0] data_o
);

    acc_size_e size_e;
    int        unit_n;
    int        base;
    int        top_lane;
    logic      fill_bit;

    assign size_e = acc_size_e'(size_i);

    always_comb begin
        unique case (size_e)
            SZ_BYTE:          unit_n = 1;
            SZ_HALF:          unit_n = 2;
            SZ_WORD, SZ_WIDE: unit_n = NLANES;
        endcase
        base     = int'(addr_i) & ~(unit_n - 1);
        top_lane = big_i ? base : (base + unit_n - 1);
        fill_bit = signed_i && (unit_n < NLANES)
                   && lanes_i[top_lane*LANE_W + LANE_W - 1];
    end

    for (genvar b = 0; b < NLANES; b++) begin : g_pos
        int                lane_v;
        logic [LANE_W-1:0] byte_v;

        always_comb begin
            lane_v = 0;
            if (b < unit_n) begin
                lane_v = big_i ? (base + unit_n - 1 - b) : (base + b);
                byte_v = lanes_i[lane_v*LANE_W +: LANE_W];
            end else begin
                byte_v = {LANE_W{fill_bit}};
            end
        end

        assign data_o[b*LANE_W +: LANE_W] = byte_v;
    end

endmodule

// File: rtl/endian_lane.sv
`timescale 1ns/1ps
module endian_lane
    import endian_lane_pkg::*;
#(
    parameter  int LANE_W = 8,
    parameter  int NLANES = 4,
    localparam int AW     = $clog2(NLANES),
    localparam int BUS_W  = LANE_W * NLANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_pin,
    input  logic              wr_valid,
    input  logic [1:0]        wr_size,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_valid,
    input  logic [1:0]        rd_size,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_signed,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              mem_wvalid,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic [NLANES-1:0] mem_wstrb,
    output logic              core_rvalid,
    output logic [BUS_W-1:0]  core_rdata,
    output logic              big_mode
);

    logic [BUS_W-1:0]  wr_lanes;
    logic [NLANES-1:0] wr_strb;
    logic [BUS_W-1:0]  rd_value;

    endian_order_fsm u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_pin  (cfg_big_pin),
        .big_mode (big_mode)
    );

    endian_wr_lane #(.LANE_W(LANE_W), .NLANES(NLANES)) u_wr (
        .big_i   (big_mode),
        .size_i  (wr_size),
        .addr_i  (wr_addr),
        .data_i  (wr_data),
        .lanes_o (wr_lanes),
        .strb_o  (wr_strb)
    );

    endian_rd_lane #(.LANE_W(LANE_W), .NLANES(NLANES)) u_rd (
        .big_i    (big_mode),
        .size_i   (rd_size),
        .addr_i   (rd_addr),
        .signed_i (rd_signed),
        .lanes_i  (mem_rdata),
        .data_o   (rd_value)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wvalid  <= 1'b0;
            mem_wdata   <= '0;
            mem_wstrb   <= '0;
            core_rvalid <= 1'b0;
            core_rdata  <= '0;
        end else begin
            mem_wvalid  <= wr_valid;
            mem_wdata   <= wr_valid ? wr_lanes : '0;
            mem_wstrb   <= wr_valid ? wr_strb  : '0;
            core_rvalid <= rd_valid;
            core_rdata  <= rd_valid ? rd_value : '0;
        end
    end

    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> mem_wvalid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wvalid |-> (mem_wstrb == '0)); // R9

    AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_size == 2'b00) |=> ($countones(mem_wstrb) == 1)); // R6

    AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_size[1]) |=> (&mem_wstrb)); // R10

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> core_rvalid); // R11

endmodule

// File: tb/endian_lane_tb_top.sv
`timescale 1ns/1ps
module endian_lane_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_pin = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_size = 2'b00;
    logic [1:0]  wr_addr = 2'b00;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_size = 2'b00;
    logic [1:0]  rd_addr = 2'b00;
    logic        rd_signed = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_wvalid;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        core_rvalid;
    logic [31:0] core_rdata;
    logic        big_mode;

    always #10 clk = ~clk; // 50 MHz

    endian_lane dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_big_pin(cfg_big_pin),
        .wr_valid(wr_valid), .wr_size(wr_size), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_size(rd_size), .rd_addr(rd_addr), .rd_signed(rd_signed),
        .mem_rdata(mem_rdata),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .core_rvalid(core_rvalid), .core_rdata(core_rdata), .big_mode(big_mode)
    );

    typedef struct packed {
        logic        wv;
        logic [3:0]  ws;
        logic [31:0] wd;
        logic        rv;
        logic [31:0] rd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    exp_big = 1'b0;
    bit    done = 1'b0;

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic int unit_of(input bit [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic int base_of(input int n, input bit [1:0] a);
        return (n == 4) ? 0 : (n == 2) ? (a[1] ? 2 : 0) : int'(a);
    endfunction

    // Memory byte i of the unit sits at lane base+i
    function automatic void model_wr(input bit big, input bit [1:0] sz, input bit [1:0] a,
                                     input bit [31:0] d, output bit [31:0] l, output bit [3:0] s);
        int n;
        int base;
        n = unit_of(sz);
        base = base_of(n, a);
        l = '0;
        s = '0;
        for (int i = 0; i < n; i++) begin
            int pos;
            pos = big ? (n - 1 - i) : i;
            l[8*(base+i) +: 8] = d[8*pos +: 8];
            s[base+i] = 1'b1;
        end
    endfunction

    function automatic bit [31:0] model_rd(input bit big, input bit [1:0] sz, input bit [1:0] a,
                                           input bit sg, input bit [31:0] l);
        int n;
        int base;
        bit [31:0] v;
        n = unit_of(sz);
        base = base_of(n, a);
        v = '0;
        for (int i = 0; i < n; i++) begin
            int pos;
            pos = big ? (n - 1 - i) : i;
            v[8*pos +: 8] = l[8*(base+i) +: 8];
        end
        if (sg && n < 4 && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
        return v;
    endfunction

    task automatic drive(input bit wv, input bit [1:0] wsz, input bit [1:0] wa, input bit [31:0] wd,
                         input bit rv, input bit [1:0] rsz, input bit [1:0] ra, input bit rsg,
                         input bit [31:0] rl, input string tag);
        exp_t e;
        bit [31:0] l;
        bit [3:0] s;
        @(negedge clk);
        wr_valid = wv; wr_size = wsz; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_size = rsz; rd_addr = ra; rd_signed = rsg; mem_rdata = rl;
        model_wr(exp_big, wsz, wa, wd, l, s);
        e.wv = wv;
        e.wd = wv ? l : '0;
        e.ws = wv ? s : '0;
        e.rv = rv;
        e.rd = rv ? model_rd(exp_big, rsz, ra, rsg, rl) : '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic drive_lit(input bit wv, input bit [1:0] sz, input bit [1:0] a, input bit [31:0] d,
                             input bit [31:0] exp_val, input bit [3:0] exp_s, input string tag);
        exp_t e;
        @(negedge clk);
        wr_valid = wv; wr_size = sz; wr_addr = a; wr_data = d;
        rd_valid = !wv; rd_size = sz; rd_addr = a; rd_signed = 1'b0; mem_rdata = d;
        e.wv = wv;
        e.wd = wv ? exp_val : '0;
        e.ws = wv ? exp_s : '0;
        e.rv = !wv;
        e.rd = wv ? '0 : exp_val;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 2'b00, 2'b00, '0, 1'b0, 2'b00, 2'b00, 1'b0, '0, tag);
    endtask

    // Monitor: results of a request appear one clock after it is driven
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " write"}, {27'b0, mem_wvalid, mem_wstrb, mem_wdata},
                      {27'b0, e.wv, e.ws, e.wd});
                check({t, " read"}, {31'b0, core_rvalid, core_rdata}, {31'b0, e.rv, e.rd});
            end
        end
    end

    task automatic do_reset(input bit pin_final);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_big_pin = ~pin_final;
        wr_valid = 1'b1; rd_valid = 1'b1;
        wr_data = 32'hFFFF_FFFF; mem_rdata = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R12 reset outputs", {27'b0, mem_wvalid, mem_wstrb, core_rvalid, mem_wdata | core_rdata},
              64'd0);
        cfg_big_pin = pin_final;
        @(negedge clk);
        @(negedge clk);
        check("R1 mode sampled in reset", {63'b0, big_mode}, {63'b0, pin_final});
        rst_n = 1'b1;
        cfg_big_pin = ~pin_final;
        wr_valid = 1'b0; rd_valid = 1'b0;
        exp_big = pin_final;
        @(negedge clk);
        @(negedge clk);
        cfg_big_pin = pin_final;
        @(negedge clk);
        cfg_big_pin = ~pin_final;
        @(negedge clk);
        check("R2 pin ignored after reset", {63'b0, big_mode}, {63'b0, pin_final});
    endtask

    task automatic run_mixed(input string mode);
        for (int sz = 0; sz < 4; sz++) begin
            for (int a = 0; a < 4; a++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    bit [31:0] wd;
                    bit [31:0] rl;
                    wd = 32'hC1B2_A390 ^ (32'h0101_0101 * (a + 4*sz + 16*sg));
                    rl = 32'h8F70_E11E ^ (32'h1122_3344 * (a + 1 + sg));
                    drive(1'b1, 2'(sz), 2'(a), wd, 1'b1, 2'(sz), 2'(3 - a), sg[0], rl,
                          $sformatf("R11 R8 R10 %s sz=%0d a=%0d sg=%0d", mode, sz, a, sg));
                end
            end
        end
        idle({"R9 idle ", mode});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Little-endian phase
        do_reset(1'b0);
        drive_lit(1'b1, 2'b10, 2'b00, 32'h1234_5678, 32'h1234_5678, 4'b1111, "R3 LE word write");
        drive_lit(1'b1, 2'b01, 2'b00, 32'h0000_00FF, 32'h0000_00FF, 4'b0011, "R5 LE half write a0");
        drive_lit(1'b1, 2'b01, 2'b11, 32'hABCD_00FF, 32'h00FF_0000, 4'b1100, "R5 LE half write a3");
        drive_lit(1'b1, 2'b00, 2'b11, 32'hDEAD_BEA5, 32'hA500_0000, 4'b1000, "R6 LE byte write a3");
        drive_lit(1'b1, 2'b11, 2'b01, 32'h1234_5678, 32'h1234_5678, 4'b1111, "R10 LE size 11 write");
        drive_lit(1'b0, 2'b10, 2'b00, 32'h7856_3412, 32'h7856_3412, 4'b0000, "R7 LE word read");
        idle("R9 LE gap");
        drive(1'b0, 2'b00, 2'b00, '0, 1'b1, 2'b00, 2'b10, 1'b1, 32'h0080_0000, "R8 LE signed byte");
        drive(1'b0, 2'b00, 2'b00, '0, 1'b1, 2'b01, 2'b10, 1'b0, 32'h80FF_0000, "R8 LE unsigned half");
        run_mixed("LE");
        // Big-endian phase
        do_reset(1'b1);
        drive_lit(1'b1, 2'b10, 2'b00, 32'h1234_5678, 32'h7856_3412, 4'b1111, "R4 BE word write");
        drive_lit(1'b1, 2'b01, 2'b00, 32'h0000_00FF, 32'h0000_FF00, 4'b0011, "R5 BE half write a0");
        drive_lit(1'b1, 2'b01, 2'b10, 32'h0000_00FF, 32'hFF00_0000, 4'b1100, "R5 BE half write a2");
        drive_lit(1'b1, 2'b00, 2'b01, 32'h0000_00A5, 32'h0000_A500, 4'b0010, "R6 BE byte write a1");
        drive_lit(1'b0, 2'b10, 2'b00, 32'h7856_3412, 32'h1234_5678, 4'b0000, "R7 BE word read");
        drive(1'b0, 2'b00, 2'b00, '0, 1'b1, 2'b01, 2'b00, 1'b1, 32'h0000_3480, "R8 BE signed half");
        drive(1'b0, 2'b00, 2'b00, '0, 1'b1, 2'b00, 2'b00, 1'b1, 32'h0000_0080, "R8 BE signed byte");
        run_mixed("BE");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule